// File: doc/BRIEF.md
# Watermarked Byte FIFO Pair with Self-Clearing Flush

This block holds two byte-wide queues that sit between a register interface and a serial engine. The transmit queue is filled by software writes and drained by the serial engine. The receive queue is filled by the serial engine and drained by software reads. Each queue has its own occupancy output and a 4-bit watermark input. The block turns occupancy into level events: empty, full, transmit nearly empty, receive nearly full, and a transmit overrun that fires when software writes a byte into a full transmit queue.

Each queue can be emptied by pulsing its flush request. That sets a busy bit which stays high for a fixed number of cycles and then clears itself. The queue is emptied at the end of that window. While the busy bit is high, every access to that queue is ignored.

The events are held in a sticky raw vector, and a masked copy of it is presented to an interrupt mask unit. Software clears a held event by pulsing its bit on the clear input.

Top module: `byte_fifo_pair`

## Requirements
- R1: Each queue holds up to 16 bytes and returns them in write order. Its level output counts the entries, from 0 to 16. Read data is presented combinationally for the entry at the head of the queue.
- R2: A transmit write while the transmit level is 16 drops the byte and leaves the level and the contents unchanged. It sets raw event bit 3 (transmit overrun) on the next clock edge.
- R3: A receive read while the receive level is 0 returns 8'h00 and leaves the level unchanged.
- R4: Three raw event bits follow the transmit queue: bit 0 is set when the transmit level is 0, bit 1 is set when the level is less than or equal to the transmit watermark (0 to 15), and bit 2 is set when the level is 16.
- R5: Three raw event bits follow the receive queue: bit 4 is set when the receive level is 0, bit 5 is set when the level is greater than or equal to the receive watermark (0 to 15), and bit 6 is set when the level is 16.
- R6: A one-cycle flush request raises that queue's busy output on the next edge. Busy stays high for exactly 4 cycles and then clears itself, and the queue's level is 0 in the same cycle. A request made while busy is already high is ignored.
- R7: While a queue's busy output is high, writes and reads of that queue are ignored: the level stays the same, read data is 8'h00, and no overrun is raised. The other queue keeps working.
- R8: Raw event bits are sticky. A clock edge sets each bit whose condition holds. A 1 on the matching bit of the clear input removes the bit, unless its condition holds in that same cycle, in which case the set wins.
- R9: The masked event output equals the raw event vector ANDed with the mask input.
- R10: After a synchronous active-low reset, both levels are 0, both busy outputs are 0, and the raw events are 0 until the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_en | input | 1 | Software write into the transmit queue |
| tx_wr_data | input | 8 | Byte to write into the transmit queue |
| tx_rd_en | input | 1 | Serial engine pops the transmit head |
| tx_rd_data | output | 8 | Transmit head byte (0 when empty or busy) |
| rx_wr_en | input | 1 | Serial engine pushes a received byte |
| rx_wr_data | input | 8 | Received byte |
| rx_rd_en | input | 1 | Software pops the receive head |
| rx_rd_data | output | 8 | Receive head byte (0 when empty or busy) |
| tx_wmark | input | 4 | Transmit nearly-empty watermark |
| rx_wmark | input | 4 | Receive nearly-full watermark |
| flush_tx_req | input | 1 | Pulse to start a transmit flush |
| flush_rx_req | input | 1 | Pulse to start a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress; clears itself |
| flush_rx_busy | output | 1 | Receive flush in progress; clears itself |
| tx_level | output | 5 | Transmit occupancy |
| rx_level | output | 5 | Receive occupancy |
| evt_mask | input | 7 | Event mask |
| evt_clr | input | 7 | Write-1 clear pulse for held events |
| evt_raw | output | 7 | Sticky raw event vector |
| evt_masked | output | 7 | Raw events ANDed with the mask |

## Verification
Two pairs of functions can land on the same edge. The first pair is an overrun and its clear: a write into a full transmit queue is driven in the same cycle as a clear of bit 3, and the bit must stay set. The second pair is a flush and traffic on both queues: while one queue is busy, both queues are written or read in the same cycle, and the levels show that only the queue not being flushed moved. The level events are swept over every occupancy from 0 to 16 against every watermark, with the expected bits computed arithmetically.

// File: rtl/fifo_pair_pkg.sv
// Package: event bit positions shared by the FIFO pair, its latch and its checker.
package fifo_pair_pkg;
    localparam int NUM_EVT      = 7;
    localparam int EVT_TX_EMPTY = 0;
    localparam int EVT_TX_NEMP  = 1;
    localparam int EVT_TX_FULL  = 2;
    localparam int EVT_TX_OVR   = 3;
    localparam int EVT_RX_EMPTY = 4;
    localparam int EVT_RX_NFULL = 5;
    localparam int EVT_RX_FULL  = 6;
endpackage

// File: rtl/byte_fifo.sv
// Module: byte_fifo
// A synchronous queue of DEPTH entries, each WIDTH bits wide, with a
// combinational head read. A write while full is dropped. A read while
// empty returns zero. The clear input empties the queue and takes
// priority over any access in the same cycle.
// Assumes: DEPTH is a power of two; the caller gates wr_en and rd_en.
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_wr, do_rd;

    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    // Head byte, or zero when the queue is empty.
    always_comb rd_data = empty ? '0 : mem[rd_ptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update; clear wins over any access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/flush_seq.sv
// Module: flush_seq
// Stretches a one-cycle flush request into a busy window of CYCLES
// clocks. On the last cycle of the window it issues a one-cycle
// done pulse, and busy falls on the following edge.
// Assumes: a request that arrives while busy is high is ignored.
module flush_seq #(
    parameter int CYCLES = 4,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(CYCLES - 1));

    // Busy window counter; clears itself at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= req;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evt_latch.sv
// Module: evt_latch
// A sticky event vector. On each edge, every bit whose condition holds
// is set. A clear pulse removes a bit unless its condition holds in the
// same cycle, in which case the set wins. The masked output is the
// sticky vector ANDed with the mask.
// Assumes: the conditions are sampled on the same clock as the clear.
module evt_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit; a set in the same cycle beats the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) raw[i] <= 1'b0;
            else        raw[i] <= (raw[i] && !clr[i]) || cond[i];
        end
    end

    assign masked = raw & mask;
endmodule

// File: rtl/byte_fifo_pair.sv
// Module: byte_fifo_pair
// A transmit queue and a receive queue, each with a self-clearing flush
// sequencer, plus the level-event logic against programmable
// watermarks and a sticky event vector for an interrupt mask unit.
// Assumes: a queue whose flush is busy ignores every access to it.
module byte_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int WIDTH   = 8,
    parameter int WM_W    = 4,
    parameter int FLUSH_N = 4,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_wr_en,
    input  logic [WIDTH-1:0]   tx_wr_data,
    input  logic               tx_rd_en,
    output logic [WIDTH-1:0]   tx_rd_data,
    input  logic               rx_wr_en,
    input  logic [WIDTH-1:0]   rx_wr_data,
    input  logic               rx_rd_en,
    output logic [WIDTH-1:0]   rx_rd_data,
    input  logic [WM_W-1:0]    tx_wmark,
    input  logic [WM_W-1:0]    rx_wmark,
    input  logic               flush_tx_req,
    input  logic               flush_rx_req,
    output logic               flush_tx_busy,
    output logic               flush_rx_busy,
    output logic [LW-1:0]      tx_level,
    output logic [LW-1:0]      rx_level,
    input  logic [NUM_EVT-1:0] evt_mask,
    input  logic [NUM_EVT-1:0] evt_clr,
    output logic [NUM_EVT-1:0] evt_raw,
    output logic [NUM_EVT-1:0] evt_masked
);
    logic tx_done, rx_done;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic [WIDTH-1:0] tx_head, rx_head;
    logic tx_ovr;
    logic [NUM_EVT-1:0] cond;

    flush_seq #(.CYCLES(FLUSH_N)) u_tx_flush (
        .clk(clk), .rst_n(rst_n), .req(flush_tx_req),
        .busy(flush_tx_busy), .done(tx_done)
    );

    flush_seq #(.CYCLES(FLUSH_N)) u_rx_flush (
        .clk(clk), .rst_n(rst_n), .req(flush_rx_req),
        .busy(flush_rx_busy), .done(rx_done)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .clear(tx_done),
        .wr_en(tx_wr_en && !flush_tx_busy), .wr_data(tx_wr_data),
        .rd_en(tx_rd_en && !flush_tx_busy), .rd_data(tx_head),
        .level(tx_level), .empty(tx_empty), .full(tx_full)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clear(rx_done),
        .wr_en(rx_wr_en && !flush_rx_busy), .wr_data(rx_wr_data),
        .rd_en(rx_rd_en && !flush_rx_busy), .rd_data(rx_head),
        .level(rx_level), .empty(rx_empty), .full(rx_full)
    );

    // Head data is hidden while its queue is being flushed.
    always_comb begin
        tx_rd_data = flush_tx_busy ? '0 : tx_head;
        rx_rd_data = flush_rx_busy ? '0 : rx_head;
    end

    // A transmit write into a full queue, outside a flush, is an overrun.
    assign tx_ovr = tx_wr_en && !flush_tx_busy && tx_full;

    // Level-event conditions, placed at their fixed bit positions.
    always_comb begin
        cond               = '0;
        cond[EVT_TX_EMPTY] = tx_empty;
        cond[EVT_TX_NEMP]  = tx_level <= LW'(tx_wmark);
        cond[EVT_TX_FULL]  = tx_full;
        cond[EVT_TX_OVR]   = tx_ovr;
        cond[EVT_RX_EMPTY] = rx_empty;
        cond[EVT_RX_NFULL] = rx_level >= LW'(rx_wmark);
        cond[EVT_RX_FULL]  = rx_full;
    end

    evt_latch #(.N(NUM_EVT)) u_evt (
        .clk(clk), .rst_n(rst_n), .cond(cond), .clr(evt_clr),
        .mask(evt_mask), .raw(evt_raw), .masked(evt_masked)
    );
endmodule

// File: rtl/byte_fifo_pair_chk.sv
// Module: byte_fifo_pair_chk
// Property checker for byte_fifo_pair. It watches the ports only and is
// attached to every instance of the block through a bind.
module byte_fifo_pair_chk
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int WM_W  = 4,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_wr_en,
    input logic               rx_rd_en,
    input logic [WIDTH-1:0]   rx_rd_data,
    input logic [WM_W-1:0]    rx_wmark,
    input logic               flush_tx_busy,
    input logic               flush_rx_busy,
    input logic [LW-1:0]      tx_level,
    input logic [LW-1:0]      rx_level,
    input logic [NUM_EVT-1:0] evt_clr,
    input logic [NUM_EVT-1:0] evt_raw
);
    // R1: occupancy never exceeds the depth.
    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

    // R2: a write into a full queue, outside a flush, raises the overrun bit.
    p_overrun_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && !flush_tx_busy && tx_level == LW'(DEPTH)) |=> evt_raw[EVT_TX_OVR]);

    // R3: reading an empty receive queue returns zero.
    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_level == '0) |-> rx_rd_data == '0);

    // R5: a receive level at or above the watermark raises bit 5.
    p_rx_nfull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= LW'(rx_wmark)) |=> evt_raw[EVT_RX_NFULL]);

    // R6: when busy falls, the queue is empty.
    p_flush_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_tx_busy) |-> tx_level == '0);

    // R7: the level holds still while a flush is in progress.
    p_flush_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_rx_busy && $past(flush_rx_busy)) |-> $stable(rx_level));

    // R8: a clear with no new overrun removes the overrun bit.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr[EVT_TX_OVR] && !(tx_wr_en && !flush_tx_busy && tx_level == LW'(DEPTH)))
        |=> !evt_raw[EVT_TX_OVR]);
endmodule

bind byte_fifo_pair byte_fifo_pair_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .WM_W(WM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .rx_wmark(rx_wmark),
    .flush_tx_busy(flush_tx_busy), .flush_rx_busy(flush_rx_busy),
    .tx_level(tx_level), .rx_level(rx_level),
    .evt_clr(evt_clr), .evt_raw(evt_raw)
);

// File: tb/byte_fifo_pair_tb.sv
module byte_fifo_pair_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_wr_en = 0, tx_rd_en = 0, rx_wr_en = 0, rx_rd_en = 0;
    logic [7:0] tx_wr_data = 0, rx_wr_data = 0, tx_rd_data, rx_rd_data;
    logic [3:0] tx_wmark = 0, rx_wmark = 4'd15;
    logic flush_tx_req = 0, flush_rx_req = 0, flush_tx_busy, flush_rx_busy;
    logic [4:0] tx_level, rx_level;
    logic [6:0] evt_mask = 7'h7F, evt_clr = 0, evt_raw, evt_masked;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_fifo_pair u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_push(input logic [7:0] d);
        @(negedge clk); tx_wr_en = 1; tx_wr_data = d;
        @(negedge clk); tx_wr_en = 0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk); rx_wr_en = 1; rx_wr_data = d;
        @(negedge clk); rx_wr_en = 0;
    endtask

    task automatic clear_all();
        @(negedge clk); evt_clr = 7'h7F;
        @(negedge clk); evt_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 tx_level", tx_level, 0);
        chk("R10 rx_level", rx_level, 0);
        chk("R10 busy", {flush_tx_busy, flush_rx_busy}, 0);
        chk("R10 raw", evt_raw, 0);
        rst_n = 1;

        // R3: empty receive read returns zero and leaves the level alone
        @(negedge clk);
        chk("R3 empty data", rx_rd_data, 0);
        rx_rd_en = 1;
        @(negedge clk); rx_rd_en = 0;
        chk("R3 empty level", rx_level, 0);

        // R4/R9: transmit level sweep against every watermark
        for (int l = 0; l <= DEPTH; l++) begin
            if (l > 0) tx_push(8'h30 + 8'(l - 1));
            chk("R1 tx_level", tx_level, l);
            for (int w = 0; w < 16; w++) begin
                logic [6:0] exp;
                @(negedge clk);
                tx_wmark = 4'(w); evt_mask = 7'(w * 37 + 5); evt_clr = 7'h7F;
                @(negedge clk); evt_clr = 0;
                exp = 7'b001_0000;
                exp[0] = (l == 0);
                exp[1] = (l <= w);
                exp[2] = (l == DEPTH);
                chk("R4 tx events", evt_raw, exp);
                chk("R9 masked", evt_masked, exp & evt_mask);
            end
        end

        // R2: overrun on a full write; the byte is dropped
        tx_push(8'hAA);
        chk("R2 overrun bit", evt_raw[3], 1);
        chk("R2 level kept", tx_level, DEPTH);
        // R8: a clear alone removes the bit
        @(negedge clk); evt_clr = 7'h08;
        @(negedge clk); evt_clr = 0;
        chk("R8 cleared", evt_raw[3], 0);
        // R8: a clear and a new overrun in the same cycle: the set wins
        @(negedge clk); evt_clr = 7'h08; tx_wr_en = 1; tx_wr_data = 8'hBB;
        @(negedge clk); evt_clr = 0; tx_wr_en = 0;
        chk("R8 set wins", evt_raw[3], 1);
        // R1/R2: drain in order; no dropped byte appears
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk("R1 tx order", tx_rd_data, 8'h30 + 8'(i));
            tx_rd_en = 1;
            @(negedge clk); tx_rd_en = 0;
        end
        chk("R1 tx drained", tx_level, 0);

        // R5: receive level sweep against every watermark
        tx_wmark = 0;
        for (int l = 0; l <= DEPTH; l++) begin
            if (l > 0) rx_push(8'hC0 + 8'(l - 1));
            for (int w = 0; w < 16; w++) begin
                logic [6:0] exp;
                @(negedge clk); rx_wmark = 4'(w); evt_clr = 7'h7F;
                @(negedge clk); evt_clr = 0;
                exp = 7'b000_0011;
                exp[4] = (l == 0);
                exp[5] = (l >= w);
                exp[6] = (l == DEPTH);
                chk("R5 rx events", evt_raw, exp);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk("R1 rx order", rx_rd_data, 8'hC0 + 8'(i));
            rx_rd_en = 1;
            @(negedge clk); rx_rd_en = 0;
        end

        // R6/R7: transmit flush while both queues see traffic
        for (int i = 0; i < 5; i++) tx_push(8'h50 + 8'(i));
        for (int i = 0; i < 3; i++) rx_push(8'h60 + 8'(i));
        @(negedge clk); flush_tx_req = 1;
        @(negedge clk); flush_tx_req = 0;
        chk("R6 busy k1", flush_tx_busy, 1);
        chk("R7 tx data hidden", tx_rd_data, 0);
        tx_wr_en = 1; tx_wr_data = 8'hEE; rx_wr_en = 1; rx_wr_data = 8'h63; tx_rd_en = 1;
        flush_tx_req = 1;
        @(negedge clk);
        tx_wr_en = 0; rx_wr_en = 0; tx_rd_en = 0; flush_tx_req = 0;
        chk("R6 busy k2", flush_tx_busy, 1);
        chk("R7 tx level frozen", tx_level, 5);
        chk("R7 rx still works", rx_level, 4);
        @(negedge clk); chk("R6 busy k3", flush_tx_busy, 1);
        @(negedge clk); chk("R6 busy k4", flush_tx_busy, 1);
        @(negedge clk);
        chk("R6 busy k5", flush_tx_busy, 0);
        chk("R6 tx flushed", tx_level, 0);
        chk("R6 rx kept", rx_level, 4);
        tx_push(8'h71);
        chk("R6 tx after flush", tx_rd_data, 8'h71);

        // R6/R7: receive flush; a read during busy returns zero, no pop
        @(negedge clk); flush_rx_req = 1;
        @(negedge clk); flush_rx_req = 0;
        chk("R7 rx data hidden", rx_rd_data, 0);
        rx_rd_en = 1;
        @(negedge clk); rx_rd_en = 0;
        chk("R7 rx level frozen", rx_level, 4);
        repeat (3) @(negedge clk);
        chk("R6 rx busy done", flush_rx_busy, 0);
        chk("R6 rx flushed", rx_level, 0);
        chk("R6 tx untouched", tx_level, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule